// File: doc/BRIEF.md
# Serial Configuration Register Bank with Staged Commit

This block is the digital control front end of a fractional-N frequency synthesizer. A host shifts 32-bit words in over three wires: a serial clock, a serial data line and a load-enable. The most significant bit goes first. The three wire inputs are brought into the system clock domain, and their edges are detected there. On each rising edge of load-enable, the word in the shift register is written to one of five configuration registers. The three low bits of the word pick the register.

The integer divide value is applied as soon as register 0 is written. The 13 low bits of the fractional word, the reference divide value, the reference doubler enable and the current setting are handled differently. Writing them only places them in a staging layer. They move to the active outputs together on the next write to register 0. The fractional word is 25 bits: its 12 upper bits come from register 0 and its 13 lower bits from register 1. Because of the staging layer, writing register 1 and then register 0 changes the whole fractional word in one cycle. Every register 0 write also raises a one-cycle update strobe.

Top module: `synth_cfg_port`

## Requirements
- R1: While `rst` is high, and after it falls, every active output is zero and `upd_o` is low. This holds until the first register 0 write.
- R2: The shift register keeps the last 32 data bits sampled on rising serial-clock edges. The bit shifted first ends up at bit 31.
- R3: Word bits 2..0 select the destination: 000 is register 0, 001 is register 1, 010 is register 2, 011 is register 3 and 100 is register 4.
- R4: A register 0 write drives `int_div_o` from word bits 30..19 and `frac_o[24:13]` from word bits 18..7. Both take effect on that write, with no staging.
- R5: A register 1 write stages word bits 27..15 as the fractional low part. `frac_o` does not change until the next register 0 write. That write then updates all 25 bits of `frac_o` in the same cycle.
- R6: A register 2 write stages three fields: word bits 19..15 as the reference divide value, bit 20 as the doubler enable and bits 27..24 as the current setting. The outputs take these values only on the next register 0 write.
- R7: A load with code 101, 110 or 111 changes no output, no staged value and produces no strobe.
- R8: `upd_o` is high for exactly one cycle per register 0 write. The active outputs change only in a cycle where `upd_o` is high.
- R9: Staged values are kept after a commit. A second register 0 write with no new staging writes re-applies the same low fractional bits, reference divide value, doubler enable and current setting.
- R10: Register 3 and register 4 writes are accepted, but they change no output of this block and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous to `clk` |
| sdata_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| le_i | input | 1 | Load-enable; a rising edge commits the word |
| int_div_o | output | 12 | Active integer divide value |
| frac_o | output | 25 | Active fractional value |
| ref_div_o | output | 5 | Active reference divide value |
| ref_dbl_o | output | 1 | Active reference doubler enable |
| cp_cur_o | output | 4 | Active current setting |
| upd_o | output | 1 | One-cycle strobe on each register 0 write |

## Verification
Several write orders are applied and the outputs are compared after each one.

- **Register 1 before register 0.** Reading `frac_o` between the two writes shows that the low half is staged and not applied directly. Reading it after the register 0 write shows that both halves change together.
- **Register 2, then register 0, then a bare register 0.** This separates three behaviours: applying settings too early, losing staged values after a commit, and keeping them as required.
- **Reserved codes and registers 3 and 4.** These words carry field patterns that would visibly change the outputs if they were decoded as register 0 or register 1.
- **A word with extra leading bits.** This checks that only the last 32 bits shifted in are used.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W = 32;
    localparam int CODE_W = 3;
    localparam int INT_W  = 12;
    localparam int FMSB_W = 12;
    localparam int FLSB_W = 13;
    localparam int FRAC_W = FMSB_W + FLSB_W;
    localparam int RDIV_W = 5;
    localparam int CUR_W  = 4;

    // field low-bit positions inside the 32-bit word
    localparam int INT_LO  = 19;
    localparam int FMSB_LO = 7;
    localparam int FLSB_LO = 15;
    localparam int RDIV_LO = 15;
    localparam int DBL_POS = 20;
    localparam int CUR_LO  = 24;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [CODE_W-1:0] {
        SEL_R0 = 3'b000,
        SEL_R1 = 3'b001,
        SEL_R2 = 3'b010,
        SEL_R3 = 3'b011,
        SEL_R4 = 3'b100
    } sel_e;

    typedef struct packed {
        logic [FLSB_W-1:0] flsb;
        logic [RDIV_W-1:0] rdiv;
        logic              dbl;
        logic [CUR_W-1:0]  cur;
    } staged_t;

    typedef struct packed {
        logic [INT_W-1:0]  int_div;
        logic [FRAC_W-1:0] frac;
        logic [RDIV_W-1:0] rdiv;
        logic              dbl;
        logic [CUR_W-1:0]  cur;
    } active_t;

    function automatic logic [CODE_W-1:0] word_code(word_t w);
        return w[CODE_W-1:0];
    endfunction

    function automatic logic [INT_W-1:0] get_int(word_t w);
        return w[INT_LO +: INT_W];
    endfunction

    function automatic logic [FMSB_W-1:0] get_fmsb(word_t w);
        return w[FMSB_LO +: FMSB_W];
    endfunction

    function automatic logic [FLSB_W-1:0] get_flsb(word_t w);
        return w[FLSB_LO +: FLSB_W];
    endfunction
endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else if (s == 0) chain[s] <= async_i;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[STAGES-1];
    end

    assign sync_o = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_en,
    input  logic  bit_i,
    output word_t word_o
);
    word_t sr_q;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], bit_i};
    end

    assign word_o = sr_q;

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  word_t   word_i,
    output active_t act_o,
    output logic    upd_o
);
    logic    wr_r0, wr_r1, wr_r2, wr_r3, wr_r4;
    staged_t stg_q;
    active_t act_q;
    logic    upd_q;
    logic    unused_bits;

    always_comb begin
        wr_r0 = 1'b0; wr_r1 = 1'b0; wr_r2 = 1'b0; wr_r3 = 1'b0; wr_r4 = 1'b0;
        if (load_i) begin
            case (word_code(word_i))
                SEL_R0:  wr_r0 = 1'b1;
                SEL_R1:  wr_r1 = 1'b1;
                SEL_R2:  wr_r2 = 1'b1;
                SEL_R3:  wr_r3 = 1'b1;
                SEL_R4:  wr_r4 = 1'b1;
                default: ;
            endcase
        end
    end

    // staging layer
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            if (wr_r1) stg_q.flsb <= get_flsb(word_i);
            if (wr_r2) begin
                stg_q.rdiv <= word_i[RDIV_LO +: RDIV_W];
                stg_q.dbl  <= word_i[DBL_POS];
                stg_q.cur  <= word_i[CUR_LO +: CUR_W];
            end
        end
    end

    // commit on register 0
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= wr_r0;
            if (wr_r0) begin
                act_q.int_div <= get_int(word_i);
                act_q.frac    <= {get_fmsb(word_i), stg_q.flsb};
                act_q.rdiv    <= stg_q.rdiv;
                act_q.dbl     <= stg_q.dbl;
                act_q.cur     <= stg_q.cur;
            end
        end
    end

    assign act_o = act_q;
    assign upd_o = upd_q;
    assign unused_bits = ^{word_i[WORD_W-1], word_i[FMSB_LO-1:CODE_W], wr_r3, wr_r4};

    // R3
    decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_r0, wr_r1, wr_r2, wr_r3, wr_r4}));
    // R8
    upd_source_chk: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> $past(load_i && word_code(word_i) == SEL_R0));
    // R8
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_q |-> $stable(act_q));
    // R5
    stage_lsb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_i && word_code(word_i) == SEL_R1) |=> $stable(stg_q.flsb));
    // R7
    reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && word_code(word_i) > SEL_R4) |=> ($stable(stg_q) && !upd_q));
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              le_i,
    output logic [INT_W-1:0]  int_div_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [RDIV_W-1:0] ref_div_o,
    output logic              ref_dbl_o,
    output logic [CUR_W-1:0]  cp_cur_o,
    output logic              upd_o
);
    logic [2:0] pins_s, pins_rise;
    word_t      word;
    active_t    act;

    cfg_in_sync #(.W(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .async_i({le_i, sdata_i, sclk_i}),
        .sync_o(pins_s), .rise_o(pins_rise)
    );

    cfg_shift u_shift (
        .clk(clk), .rst(rst),
        .shift_en(pins_rise[0]), .bit_i(pins_s[1]),
        .word_o(word)
    );

    cfg_reg_bank u_bank (
        .clk(clk), .rst(rst),
        .load_i(pins_rise[2]), .word_i(word),
        .act_o(act), .upd_o(upd_o)
    );

    assign int_div_o = act.int_div;
    assign frac_o    = act.frac;
    assign ref_div_o = act.rdiv;
    assign ref_dbl_o = act.dbl;
    assign cp_cur_o  = act.cur;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (frac_o == '0 && int_div_o == '0 && !upd_o));
endmodule

// File: tb/synth_cfg_port_tb.sv
module synth_cfg_port_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdata = 1'b0, le = 1'b0;
    logic [11:0] int_div;
    logic [24:0] frac;
    logic [4:0]  rdiv;
    logic        dbl;
    logic [3:0]  cur;
    logic        upd;

    int n_checks = 0;
    int n_fail   = 0;
    int n_upd    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_port u_dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
        .int_div_o(int_div), .frac_o(frac), .ref_div_o(rdiv),
        .ref_dbl_o(dbl), .cp_cur_o(cur), .upd_o(upd)
    );

    always @(negedge clk) if (!rst && upd) n_upd++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_r0(logic [11:0] iv, logic [11:0] fm);
        return {1'b0, iv, fm, 4'b0, 3'b000};
    endfunction
    function automatic logic [31:0] mk_r1(logic [12:0] fl);
        return {4'b0, fl, 12'b0, 3'b001};
    endfunction
    function automatic logic [31:0] mk_r2(logic [3:0] c, logic d, logic [4:0] r);
        return {4'b0, c, 3'b0, d, r, 12'b0, 3'b010};
    endfunction

    task automatic shift_bit(logic b);
        @(negedge clk); sdata = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic load_pulse();
        repeat (2) @(negedge clk);
        le = 1'b1;
        repeat (3) @(negedge clk);
        le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_word(logic [31:0] w);
        for (int i = 31; i >= 0; i--) shift_bit(w[i]);
        load_pulse();
    endtask

    task automatic check_outs(string req, logic [11:0] iv, logic [24:0] fr,
                              logic [4:0] r, logic d, logic [3:0] c);
        check({req, " int"},  int_div, iv);
        check({req, " frac"}, frac, fr);
        check({req, " rdiv"}, rdiv, r);
        check({req, " dbl"},  dbl, d);
        check({req, " cur"},  cur, c);
    endtask

    task automatic test_reset();
        check_outs("R1 reset", 12'h0, 25'h0, 5'h0, 1'b0, 4'h0);
        check("R1 upd", upd, 0);
    endtask

    task automatic test_r0_direct();
        int u0 = n_upd;
        send_word(mk_r0(12'hA5C, 12'h3F1));
        // R4: R3 code 000 selects register 0
        check_outs("R4", 12'hA5C, {12'h3F1, 13'h0}, 5'h0, 1'b0, 4'h0);
        check("R8 strobe count", n_upd - u0, 1);
    endtask

    task automatic test_frac_atomic();
        int u0 = n_upd;
        send_word(mk_r1(13'h1ABC));
        check("R5 frac held", frac, {12'h3F1, 13'h0});
        check("R8 no strobe on R1", n_upd - u0, 0);
        send_word(mk_r0(12'h123, 12'h876));
        check("R5 frac commit", frac, {12'h876, 13'h1ABC});
        check("R3 int", int_div, 12'h123);
    endtask

    task automatic test_r2_staged();
        send_word(mk_r2(4'hB, 1'b1, 5'h15));
        check("R6 rdiv held", rdiv, 0);
        check("R6 dbl held", dbl, 0);
        check("R6 cur held", cur, 0);
        send_word(mk_r0(12'h200, 12'h001));
        check_outs("R6 commit", 12'h200, {12'h001, 13'h1ABC}, 5'h15, 1'b1, 4'hB);
        send_word(mk_r0(12'h201, 12'h002));
        check_outs("R9 reapply", 12'h201, {12'h002, 13'h1ABC}, 5'h15, 1'b1, 4'hB);
    endtask

    task automatic test_ignored();
        int u0 = n_upd;
        logic [31:0] pat;
        for (int c = 5; c <= 7; c++) begin
            pat = 32'h7FFF_FFF8 | 32'(c);
            send_word(pat);
            check_outs("R7 ignored", 12'h201, {12'h002, 13'h1ABC}, 5'h15, 1'b1, 4'hB);
        end
        check("R7 no strobe", n_upd - u0, 0);
        send_word(32'h0FFF_FFFB);
        send_word(32'h0FFF_FFFC);
        check_outs("R10 r3/r4", 12'h201, {12'h002, 13'h1ABC}, 5'h15, 1'b1, 4'hB);
        check("R10 no strobe", n_upd - u0, 0);
        // staged values untouched by the ignored words
        send_word(mk_r0(12'h0F0, 12'h0F0));
        check_outs("R7 stage intact", 12'h0F0, {12'h0F0, 13'h1ABC}, 5'h15, 1'b1, 4'hB);
    endtask

    task automatic test_overlong();
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
        send_word(mk_r0(12'h801, 12'hC03));
        check("R2 int", int_div, 12'h801);
        check("R2 frac msb", frac[24:13], 12'hC03);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        test_reset();
        test_r0_direct();
        test_frac_atomic();
        test_r2_staged();
        test_ignored();
        test_overlong();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule